// File: doc/BRIEF.md
# Open-Drain Port Mode Negotiation

This block sets the speed and duplex of one 10/100 Ethernet MAC port through two shared open-drain strap lines. One line carries speed and the other carries duplex. A high line selects the faster or full-duplex option. The MAC side and the PHY side can each pull a line low, and either pull forces the slower or half-duplex option. The lines therefore resolve as a wired-AND. The block drives the output enable of each line from request bits that a configuration store loads. It reads back the resolved line levels, along with a link pin, through a synchronizer into a status register. The speed, duplex and link values come from that status register.

The configuration store writes the slow, half and pause request bits with a single strobe and then signals that loading is done. Until that signal arrives, the PHY is held in reset, so it cannot latch the straps before the requests are in place. The pause request is sent to the MAC only and never reaches a line. Each change in the resolved speed or duplex raises a one-cycle pulse toward the MAC.

Top module: `port_mode_negot`

## Requirements
- R1: While `cfg_wr_i` is high at a clock edge, `cfg_slow_i` is stored. From the next cycle onward, `spd_pull_o` equals the stored bit. A 1 pulls the speed line low and a 0 releases it.
- R2: The duplex request works the same way. `cfg_half_i` is stored on a write and drives `dup_pull_o`, where a 1 pulls the duplex line low.
- R3: `mac_fast_o` shows the level of `spd_line_i` from three clock edges earlier (two synchronizer stages plus the status register). A 1 means 100 Mbit/s and a 0 means 10 Mbit/s. If the PHY pulls the line low, the result is 10 Mbit/s whatever the request bit holds.
- R4: `mac_full_o` follows `dup_line_i` with the same three-edge latency. A 1 means full duplex and a 0 means half duplex. A PHY pull forces half duplex whatever the request bit holds.
- R5: `link_o` follows `link_i` with the same latency. The link input never changes the speed or duplex status, and it never raises `mode_chg_o`.
- R6: `phy_rst_no` is low from reset until `cfg_done_i` is seen high at a clock edge. It is high from the next cycle and stays high until the next reset.
- R7: A write stores `cfg_pause_i` and presents it on `mac_pause_o` from the next cycle. The pause bit never changes `spd_pull_o` or `dup_pull_o`.
- R8: During reset, all request bits are 0, both pulls are released, and status, link and `mode_chg_o` are 0.
- R9: `mode_chg_o` is high for exactly the one cycle in which the speed or duplex status takes a new value. It stays low for the first valid sample after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Load strobe for the request bits |
| cfg_slow_i | input | 1 | Speed request: 1 forces 10 Mbit/s |
| cfg_half_i | input | 1 | Duplex request: 1 forces half duplex |
| cfg_pause_i | input | 1 | Pause enable for the MAC |
| cfg_done_i | input | 1 | Configuration loading finished |
| spd_line_i | input | 1 | Resolved level of the speed line |
| dup_line_i | input | 1 | Resolved level of the duplex line |
| link_i | input | 1 | Link indication from the PHY |
| spd_pull_o | output | 1 | Output enable pulling the speed line low |
| dup_pull_o | output | 1 | Output enable pulling the duplex line low |
| phy_rst_no | output | 1 | PHY reset, active low |
| mac_fast_o | output | 1 | Status: 1 = 100 Mbit/s |
| mac_full_o | output | 1 | Status: 1 = full duplex |
| mac_pause_o | output | 1 | Stored pause enable |
| link_o | output | 1 | Synchronized link status |
| mode_chg_o | output | 1 | One-cycle pulse when speed or duplex changes |

## Verification
The assertions assume the line inputs are the wired-AND of this block's pulls and the PHY's pulls. They also assume every input holds its level across a clock edge, so a three-cycle-old line level is a valid reference for the status. The bench models each line as the inverted OR of the two pulls and changes the inputs only on falling edges. In each step it changes only one thing: a configuration write, a PHY pull pattern or the link level. This way every resolved transition is single and clean, and the expected count of change pulses is unambiguous.

// File: rtl/pmn_pkg.sv
package pmn_pkg;
  typedef struct packed {
    logic pause;
    logic half;
    logic slow;
  } pmn_req_t;

  localparam int unsigned PMN_LINES = 3;
  localparam int unsigned LN_SPD    = 0;
  localparam int unsigned LN_DUP    = 1;
  localparam int unsigned LN_LNK    = 2;
endpackage

// File: rtl/pmn_ctrl_reg.sv
module pmn_ctrl_reg
  import pmn_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  pmn_req_t req_i,
  input  logic     done_i,
  output pmn_req_t req_o,
  output logic     loaded_o
);
  pmn_req_t req_q;
  logic     loaded_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q    <= '0;
      loaded_q <= 1'b0;
    end else begin
      if (wr_i) req_q <= req_i;
      if (done_i) loaded_q <= 1'b1; // sticky until reset
    end
  end

  assign req_o    = req_q;
  assign loaded_o = loaded_q;
endmodule

// File: rtl/pmn_sync.sv
module pmn_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else if (STAGES == 1) chain_q <= d_i[b];
      else chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/pmn_status.sv
module pmn_status
  import pmn_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PMN_LINES-1:0] smp_i,
  output logic [PMN_LINES-1:0] st_o,
  output logic                 chg_o
);
  localparam int unsigned FILL = STAGES + 1;
  localparam int unsigned CW   = $clog2(FILL + 1);

  logic [PMN_LINES-1:0] st_q;
  logic [CW-1:0]        fill_q;
  logic                 chg_q;
  logic                 primed;
  logic                 mode_diff;

  // status already holds a real sample before this edge
  assign primed    = (fill_q == CW'(FILL));
  assign mode_diff = (smp_i[LN_SPD] != st_q[LN_SPD]) || (smp_i[LN_DUP] != st_q[LN_DUP]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      fill_q <= '0;
      chg_q  <= 1'b0;
    end else begin
      st_q  <= smp_i;
      chg_q <= primed && mode_diff;
      if (!primed) fill_q <= fill_q + 1'b1;
    end
  end

  assign st_o  = st_q;
  assign chg_o = chg_q;
endmodule

// File: rtl/port_mode_negot.sv
module port_mode_negot
  import pmn_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_wr_i,
  input  logic cfg_slow_i,
  input  logic cfg_half_i,
  input  logic cfg_pause_i,
  input  logic cfg_done_i,
  input  logic spd_line_i,
  input  logic dup_line_i,
  input  logic link_i,
  output logic spd_pull_o,
  output logic dup_pull_o,
  output logic phy_rst_no,
  output logic mac_fast_o,
  output logic mac_full_o,
  output logic mac_pause_o,
  output logic link_o,
  output logic mode_chg_o
);
  pmn_req_t             req_in, req_q;
  logic                 loaded;
  logic [PMN_LINES-1:0] pins, smp, st;

  assign req_in = '{pause: cfg_pause_i, half: cfg_half_i, slow: cfg_slow_i};

  pmn_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_wr_i),
    .req_i   (req_in),
    .done_i  (cfg_done_i),
    .req_o   (req_q),
    .loaded_o(loaded)
  );

  assign pins[LN_SPD] = spd_line_i;
  assign pins[LN_DUP] = dup_line_i;
  assign pins[LN_LNK] = link_i;

  pmn_sync #(.STAGES(SYNC_STAGES), .WIDTH(PMN_LINES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins),
    .q_o   (smp)
  );

  pmn_status #(.STAGES(SYNC_STAGES)) u_stat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .smp_i (smp),
    .st_o  (st),
    .chg_o (mode_chg_o)
  );

  // pause never reaches a line
  assign spd_pull_o  = req_q.slow;
  assign dup_pull_o  = req_q.half;
  assign mac_pause_o = req_q.pause;
  assign phy_rst_no  = loaded;
  assign mac_fast_o  = st[LN_SPD];
  assign mac_full_o  = st[LN_DUP];
  assign link_o      = st[LN_LNK];
endmodule

// File: rtl/pmn_checker.sv
module pmn_checker #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_wr_i,
  input logic cfg_slow_i,
  input logic cfg_half_i,
  input logic cfg_pause_i,
  input logic cfg_done_i,
  input logic spd_line_i,
  input logic dup_line_i,
  input logic link_i,
  input logic spd_pull_o,
  input logic dup_pull_o,
  input logic phy_rst_no,
  input logic mac_fast_o,
  input logic mac_full_o,
  input logic mac_pause_o,
  input logic link_o,
  input logic mode_chg_o
);
  localparam int unsigned LAT = SYNC_STAGES + 1;
  logic [3:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != 4'hf) cyc_q <= cyc_q + 1'b1;
  end

  p_spd_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> spd_pull_o == $past(cfg_slow_i));
  p_dup_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> dup_pull_o == $past(cfg_half_i));
  p_spd_stat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q > 4'(LAT + 1)) |-> mac_fast_o == $past(spd_line_i, LAT));
  p_dup_stat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q > 4'(LAT + 1)) |-> mac_full_o == $past(dup_line_i, LAT));
  p_link_stat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q > 4'(LAT + 1)) |-> link_o == $past(link_i, LAT));
  p_rst_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phy_rst_no) |-> $past(cfg_done_i));
  p_rst_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(phy_rst_no));
  p_pause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> mac_pause_o == $past(cfg_pause_i));
  p_no_wr_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_wr_i |=> $stable(spd_pull_o) && $stable(dup_pull_o) && $stable(mac_pause_o));
  p_chg_real_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_o |-> (mac_fast_o != $past(mac_fast_o)) || (mac_full_o != $past(mac_full_o)));

  always_comb begin
    if (!rst_ni) begin
      a_reset_r8: assert (!spd_pull_o && !dup_pull_o && !mode_chg_o && !phy_rst_no);
    end
  end
endmodule

bind port_mode_negot pmn_checker #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_wr_i(cfg_wr_i), .cfg_slow_i(cfg_slow_i),
  .cfg_half_i(cfg_half_i), .cfg_pause_i(cfg_pause_i), .cfg_done_i(cfg_done_i),
  .spd_line_i(spd_line_i), .dup_line_i(dup_line_i), .link_i(link_i),
  .spd_pull_o(spd_pull_o), .dup_pull_o(dup_pull_o), .phy_rst_no(phy_rst_no),
  .mac_fast_o(mac_fast_o), .mac_full_o(mac_full_o), .mac_pause_o(mac_pause_o),
  .link_o(link_o), .mode_chg_o(mode_chg_o)
);

// File: tb/port_mode_negot_tb_top.sv
module port_mode_negot_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_wr, cfg_slow, cfg_half, cfg_pause, cfg_done, link;
  logic phy_spd, phy_dup;
  logic spd_line, dup_line;
  logic spd_pull, dup_pull, phy_rst_n, mac_fast, mac_full, mac_pause, link_q, mode_chg;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // cur_* track the request bits the bench has written
  logic cur_slow = 1'b0, cur_half = 1'b0, cur_pause = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // wired-AND of the two open-drain sides with pullup
  assign spd_line = ~(spd_pull | phy_spd);
  assign dup_line = ~(dup_pull | phy_dup);

  port_mode_negot dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_wr_i(cfg_wr), .cfg_slow_i(cfg_slow),
    .cfg_half_i(cfg_half), .cfg_pause_i(cfg_pause), .cfg_done_i(cfg_done),
    .spd_line_i(spd_line), .dup_line_i(dup_line), .link_i(link),
    .spd_pull_o(spd_pull), .dup_pull_o(dup_pull), .phy_rst_no(phy_rst_n),
    .mac_fast_o(mac_fast), .mac_full_o(mac_full), .mac_pause_o(mac_pause),
    .link_o(link_q), .mode_chg_o(mode_chg)
  );

  function automatic logic exp_level(input logic req, input logic phy);
    return ~(req | phy);
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic check_int(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic cfg_write(input logic s, input logic h, input logic p);
    cfg_wr = 1'b1; cfg_slow = s; cfg_half = h; cfg_pause = p;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_slow = $urandom; cfg_half = $urandom; cfg_pause = $urandom;
    cur_slow = s; cur_half = h; cur_pause = p;
  endtask

  // wait n cycles, return the number of cycles mode_chg was high
  task automatic settle(input int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mode_chg) pulses++;
    end
  endtask

  task automatic check_state(input string tag);
    check("R1", {tag, " spd_pull"}, spd_pull, cur_slow);
    check("R2", {tag, " dup_pull"}, dup_pull, cur_half);
    check("R3", {tag, " mac_fast"}, mac_fast, exp_level(cur_slow, phy_spd));
    check("R4", {tag, " mac_full"}, mac_full, exp_level(cur_half, phy_dup));
    check("R5", {tag, " link_o"}, link_q, link);
    check("R7", {tag, " mac_pause"}, mac_pause, cur_pause);
  endtask

  initial begin
    for (int c = 0; c < WDOG_CYCLES; c++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    int p;
    logic old_f, old_d;
    void'($urandom(32'h5eed_0017));
    cfg_wr = 0; cfg_slow = 0; cfg_half = 0; cfg_pause = 0; cfg_done = 0;
    link = 0; phy_spd = 0; phy_dup = 0;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8", "reset spd_pull", spd_pull, 1'b0);
    check("R8", "reset dup_pull", dup_pull, 1'b0);
    check("R8", "reset mac_fast", mac_fast, 1'b0);
    check("R8", "reset mode_chg", mode_chg, 1'b0);
    check("R6", "reset phy_rst_no", phy_rst_n, 1'b0);

    rst_ni = 1'b1;
    settle(6, p);
    check_int("R9", "no pulse on first fill", p, 0);
    check("R3", "fill mac_fast", mac_fast, 1'b1);
    check("R4", "fill mac_full", mac_full, 1'b1);
    check("R6", "held before done", phy_rst_n, 1'b0);

    cfg_write(1'b1, 1'b0, 1'b1);
    check("R1", "pull after write", spd_pull, 1'b1);
    check("R2", "dup released", dup_pull, 1'b0);
    check("R7", "pause stored", mac_pause, 1'b1);
    check("R6", "still held", phy_rst_n, 1'b0);
    settle(6, p);
    check_int("R9", "speed drop pulse", p, 1);
    check_state("slow req");

    cfg_done = 1'b1;
    @(negedge clk);
    cfg_done = 1'b0;
    check("R6", "released after done", phy_rst_n, 1'b1);

    // R3 latency and PHY override on a released line
    cfg_write(1'b0, 1'b0, 1'b1);
    settle(6, p);
    check_int("R9", "speed rise pulse", p, 1);
    phy_spd = 1'b1;
    @(negedge clk);
    check("R3", "latency edge1", mac_fast, 1'b1);
    @(negedge clk);
    check("R3", "latency edge2", mac_fast, 1'b1);
    check("R9", "no early pulse", mode_chg, 1'b0);
    @(negedge clk);
    check("R3", "latency edge3 phy override", mac_fast, 1'b0);
    check("R9", "pulse with change", mode_chg, 1'b1);
    @(negedge clk);
    check("R9", "pulse one cycle", mode_chg, 1'b0);

    // R7 pause-only write leaves lines alone
    cfg_write(1'b0, 1'b0, 1'b0);
    check("R7", "pause clear", mac_pause, 1'b0);
    check("R7", "spd pull untouched", spd_pull, 1'b0);
    check("R7", "dup pull untouched", dup_pull, 1'b0);
    settle(6, p);
    check_int("R7", "no mode change from pause", p, 0);

    // R5 link toggles only link_o
    link = 1'b1;
    settle(6, p);
    check_int("R5", "no pulse from link", p, 0);
    check("R5", "link up", link_q, 1'b1);
    check("R5", "speed unaffected", mac_fast, 1'b0);

    // R2/R4 duplex request overrides a full-duplex PHY
    phy_spd = 1'b0;
    settle(6, p);
    cfg_write(1'b0, 1'b1, 1'b0);
    settle(6, p);
    check_int("R9", "duplex drop pulse", p, 1);
    check_state("half req");

    for (int it = 0; it < 80; it++) begin
      int kind;
      kind = $urandom_range(0, 2);
      old_f = exp_level(cur_slow, phy_spd);
      old_d = exp_level(cur_half, phy_dup);
      case (kind)
        0: cfg_write(1'($urandom), 1'($urandom), 1'($urandom));
        1: begin phy_spd = 1'($urandom); phy_dup = 1'($urandom); end
        default: link = ~link;
      endcase
      settle(6, p);
      check_int("R9", "random pulse count", p,
                ((old_f != exp_level(cur_slow, phy_spd)) ||
                 (old_d != exp_level(cur_half, phy_dup))) ? 1 : 0);
      check_state("random");
    end

    check("R6", "stays released", phy_rst_n, 1'b1);
    finish_sim();
  end
endmodule